// File: doc/BRIEF.md
# Reset-Time Boot Image Copier

This block sits between the reset pin and a processor core. While reset is low, the block and the core stay in their reset state. When reset is released, the block reads a fixed-size boot image from the base of an external memory region and writes it into internal memory from address zero. During the whole copy the core is held stalled. After the last word has been written, the block releases the core so that it starts fetching at address zero.

The external side is a simple read port. The block raises a request together with a byte address and holds both until the memory returns a data-valid strobe. The internal side is a single-cycle write port. A static mode input chooses between a boot copy and no-boot. In no-boot mode the core is released straight after reset and no memory traffic occurs.

Bytes keep their addresses across the copy in little-endian order. Each word read or written carries its lowest-addressed byte in bits [7:0].

Top module: `boot_copier`

## Requirements
- R1: While rst_n is low, rd_req, wr_en, core_run and done are all 0. This holds from the moment reset falls, with no clock edge needed.
- R2: With boot_en=1, rd_req goes high on the first clock edge after reset is released. The successive reads use byte addresses SRC_BASE, SRC_BASE+4, SRC_BASE+8 and so on. Only one read is outstanding at a time, and rd_req and rd_addr stay unchanged until rd_valid is sampled high.
- R3: A boot copy makes exactly IMG_BYTES/4 writes (256 by default). They go to byte addresses DST_BASE (0), DST_BASE+4 and so on up to DST_BASE+1020, in ascending order, and each one is a single-cycle wr_en pulse.
- R4: core_run stays 0 for the whole copy. It rises on the clock edge that ends the cycle of the last write.
- R5: The byte at source offset n lands at destination byte address n. On both ports, the lowest-addressed byte of a 32-bit word sits in bits [7:0] (little-endian).
- R6: An rd_valid pulse that arrives while rd_req is 0 has no effect: no write, no address step and no state change.
- R7: With boot_en=0, core_run and done rise on the first clock edge after reset release, and no read or write occurs.
- R8: core_run and done rise together and stay high until the next reset. After that point, rd_req and wr_en stay 0.
- R9: Asserting reset during a copy aborts it. The next reset release starts a full copy again from SRC_BASE to DST_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Static mode: 1 = copy the image, 0 = no-boot |
| rd_req | output | 1 | Read request to external memory |
| rd_addr | output | AW (32) | Byte address of the requested read |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | RD_W (32) | Read data, little-endian |
| wr_en | output | 1 | Internal memory write strobe |
| wr_addr | output | AW (32) | Internal memory byte address |
| wr_data | output | WR_W (32) | Internal memory write data, little-endian |
| core_run | output | 1 | Releases the core (1 = run from address 0) |
| done | output | 1 | Boot sequence complete, sticky until reset |

## Verification
The copy is driven with a zero-wait memory, with a memory whose latency cycles through 0 to 3 per word, and with a fixed one-cycle latency. Agreement across these runs shows that the request-hold handshake does not depend on timing. Each run uses a different byte pattern that varies with position inside the word, so any byte swap or word shift shows up against the little-endian expectation. A reset in the middle of a copy, followed by a full restart, separates a true restart from one that resumes at the old counters. Stray valid strobes sent after completion, and a no-boot run, check that the core release is sticky and that it goes out without any traffic.

// File: rtl/boot_copier_pkg.sv
package boot_copier_pkg;

   typedef enum logic [1:0] {
      BC_IDLE  = 2'd0,
      BC_READ  = 2'd1,
      BC_WRITE = 2'd2,
      BC_DONE  = 2'd3
   } bc_state_e;

   function automatic int bc_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bc_seq.sv
module bc_seq
   import boot_copier_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      boot_en,
   input  logic      beat_take,
   input  logic      beat_last,
   input  logic      last_word,
   output bc_state_e state,
   output logic      done_q
);

   bc_state_e state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         BC_IDLE:  state_d = boot_en ? BC_READ : BC_DONE;
         BC_READ:  if (beat_take && beat_last) state_d = BC_WRITE;
         BC_WRITE: state_d = last_word ? BC_DONE : BC_READ;
         BC_DONE:  state_d = BC_DONE;
         default:  state_d = BC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= BC_IDLE;
         done_q <= 1'b0;
      end else begin
         state <= state_d;
         if (state != BC_DONE && state_d == BC_DONE) done_q <= 1'b1;
      end
   end

   AST_WRITE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BC_WRITE) |-> $past(beat_take && beat_last)) else $error("write without read"); // R6

endmodule

// File: rtl/bc_addr_gen.sv
module bc_addr_gen
   import boot_copier_pkg::*;
#(
   parameter int             AW        = 32,
   parameter int             RD_W      = 32,
   parameter int             WR_W      = 32,
   parameter int             IMG_BYTES = 1024,
   parameter logic [AW-1:0]  SRC_BASE  = 32'h6000_0000,
   parameter logic [AW-1:0]  DST_BASE  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beat_take,
   input  logic          word_commit,
   output logic [AW-1:0] rd_addr,
   output logic [AW-1:0] wr_addr,
   output logic          beat_last,
   output logic          last_word
);

   localparam int RB    = RD_W / 8;
   localparam int WB    = WR_W / 8;
   localparam int BEATS = WR_W / RD_W;
   localparam int WORDS = IMG_BYTES / WB;
   localparam int WI_W  = bc_idx_w(WORDS);
   localparam int BI_W  = bc_idx_w(BEATS);

   logic [WI_W-1:0] word_q;
   logic [AW-1:0]   word_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q <= '0;
      else if (word_commit) word_q <= word_q + 1'b1;
   end

   assign word_off  = AW'(word_q) * AW'(WB);
   assign wr_addr   = DST_BASE + word_off;
   assign last_word = (word_q == WI_W'(WORDS - 1));

   generate
      if (BEATS == 1) begin : g_single
         wire unused_take = beat_take;
         assign beat_last = 1'b1;
         assign rd_addr   = SRC_BASE + word_off;
      end else begin : g_multi
         logic [BI_W-1:0] beat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          beat_q <= '0;
            else if (beat_take)  beat_q <= beat_last ? '0 : beat_q + 1'b1;
         end
         assign beat_last = (beat_q == BI_W'(BEATS - 1));
         assign rd_addr   = SRC_BASE + word_off + AW'(beat_q) * AW'(RB);
      end
   endgenerate

   AST_NO_WORD_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      word_commit && last_word |=> !word_commit) else $error("write past image end"); // R3

endmodule

// File: rtl/bc_pack.sv
module bc_pack #(
   parameter int RD_W = 32,
   parameter int WR_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [RD_W-1:0] rd_data,
   output logic [WR_W-1:0] word
);

   generate
      if (RD_W == WR_W) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    word <= '0;
            else if (take) word <= rd_data;
         end
      end else begin : g_shift
         // earliest beat (lowest address) ends up in the low bits
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    word <= '0;
            else if (take) word <= {rd_data, word[WR_W-1:RD_W]};
         end
      end
   endgenerate

endmodule

// File: rtl/boot_copier.sv
module boot_copier
   import boot_copier_pkg::*;
#(
   parameter int             AW        = 32,
   parameter int             RD_W      = 32,
   parameter int             WR_W      = 32,
   parameter int             IMG_BYTES = 1024,
   parameter logic [AW-1:0]  SRC_BASE  = 32'h6000_0000,
   parameter logic [AW-1:0]  DST_BASE  = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boot_en,
   output logic            rd_req,
   output logic [AW-1:0]   rd_addr,
   input  logic            rd_valid,
   input  logic [RD_W-1:0] rd_data,
   output logic            wr_en,
   output logic [AW-1:0]   wr_addr,
   output logic [WR_W-1:0] wr_data,
   output logic            core_run,
   output logic            done
);

   generate
      if (RD_W % 8 != 0 || RD_W < 8)       begin : g_bad_rd  $error("RD_W must be whole bytes"); end
      if (WR_W % RD_W != 0)                begin : g_bad_ratio $error("WR_W must be a multiple of RD_W"); end
      if (IMG_BYTES % (WR_W / 8) != 0)     begin : g_bad_img $error("IMG_BYTES must be whole words"); end
      if (IMG_BYTES < WR_W / 8)            begin : g_small_img $error("IMG_BYTES below one word"); end
   endgenerate

   bc_state_e state;
   logic      beat_take, beat_last, last_word, done_q;

   assign rd_req    = (state == BC_READ);
   assign wr_en     = (state == BC_WRITE);
   assign core_run  = (state == BC_DONE);
   assign done      = done_q;
   assign beat_take = rd_req & rd_valid;

   bc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_en   (boot_en),
      .beat_take (beat_take),
      .beat_last (beat_last),
      .last_word (last_word),
      .state     (state),
      .done_q    (done_q)
   );

   bc_addr_gen #(
      .AW(AW), .RD_W(RD_W), .WR_W(WR_W), .IMG_BYTES(IMG_BYTES),
      .SRC_BASE(SRC_BASE), .DST_BASE(DST_BASE)
   ) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .beat_take   (beat_take),
      .word_commit (wr_en),
      .rd_addr     (rd_addr),
      .wr_addr     (wr_addr),
      .beat_last   (beat_last),
      .last_word   (last_word)
   );

   bc_pack #(.RD_W(RD_W), .WR_W(WR_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (beat_take),
      .rd_data (rd_data),
      .word    (wr_data)
   );

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_valid |=> rd_req && $stable(rd_addr)) else $error("request dropped"); // R2
   AST_CORE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !core_run) else $error("core ran during copy"); // R4
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |=> core_run && done) else $error("release not sticky"); // R8
   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req && !wr_en && core_run) else $error("traffic after done"); // R8
   AST_NOBOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_en |-> !rd_req && !wr_en) else $error("traffic in no-boot"); // R7

endmodule

// File: tb/sim_boot_copier.sv
module sim_boot_copier;

   localparam int          WORDS = 256;
   localparam logic [31:0] SRC   = 32'h6000_0000;
   localparam int          LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_en = 1'b1;
   logic        rd_req, wr_en, core_run, done;
   logic [31:0] rd_addr, wr_addr, wr_data;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_data = '0;

   always #5 clk = ~clk;

   boot_copier u0 (
      .clk(clk), .rst_n(rst_n), .boot_en(boot_en),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .core_run(core_run), .done(done)
   );

   typedef struct packed { logic [31:0] a; logic [31:0] d; } exp_t;
   exp_t exp_q[$];

   int tests = 0, fails = 0;       // main
   int m_tests = 0, m_fails = 0;   // monitor
   int r_tests = 0, r_fails = 0;   // responder
   int cyc = 0;
   int seed = 0, lat_mode = 0, stray_want = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] byte_at(input int n, input int s);
      return 8'((n * 7 + 3) ^ (n >> 8) ^ (s * 37));
   endfunction

   function automatic logic [31:0] word_at(input int k, input int s);
      return {byte_at(4*k+3, s), byte_at(4*k+2, s), byte_at(4*k+1, s), byte_at(4*k, s)};
   endfunction

   function automatic int lat_of(input int idx, input int mode);
      if (mode == 0) return 0;
      if (mode == 1) return idx % 4;
      return 1;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory responder
   int rd_idx = 0, wait_cnt = -1, stray_done = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_valid = 1'b0; rd_idx = 0; wait_cnt = -1;
      end else if (rd_valid) begin
         rd_valid = 1'b0;
      end else if (rd_req) begin
         if (wait_cnt < 0) wait_cnt = lat_of(rd_idx, lat_mode);
         if (wait_cnt == 0) begin
            r_tests++;
            if (rd_addr !== SRC + 32'(rd_idx * 4)) begin
               r_fails++;
               $display("FAIL R2 read address: actual %0h expected %0h", rd_addr, SRC + 32'(rd_idx * 4));
            end
            rd_data  = word_at(rd_idx, seed);
            rd_valid = 1'b1;
            rd_idx++;
            wait_cnt = -1;
         end else wait_cnt--;
      end else if (stray_done < stray_want) begin
         rd_data  = 32'hDEAD_BEEF;
         rd_valid = 1'b1;   // R6 stray strobe while no request
         stray_done++;
      end
   end

   // scoreboard monitor
   int wr_cnt = 0, req_cnt = 0;
   bit last_seen = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         wr_cnt = 0; req_cnt = 0; last_seen = 0;
      end else begin
         if (rd_req) req_cnt++;
         if (last_seen) begin
            m_tests++;
            if (!(core_run && done)) begin
               m_fails++;
               $display("FAIL R4 release after last write: actual %0b%0b expected 11", core_run, done);
            end
            last_seen = 0;
         end
         if (core_run && (rd_req || wr_en)) begin
            m_tests++; m_fails++;
            $display("FAIL R8 traffic after release: actual %0b%0b expected 00", rd_req, wr_en);
         end
         if (wr_en) begin
            exp_t e;
            m_tests++;
            if (exp_q.size() == 0) begin
               m_fails++;
               $display("FAIL R3 unexpected write: actual %0h expected none", wr_addr);
            end else begin
               e = exp_q.pop_front();
               if (wr_addr !== e.a || wr_data !== e.d) begin
                  m_fails++;
                  $display("FAIL R3 R5 write: actual %0h/%0h expected %0h/%0h", wr_addr, wr_data, e.a, e.d);
               end
            end
            if (core_run) begin
               m_fails++;
               $display("FAIL R4 core ran during copy: actual 1 expected 0");
            end
            wr_cnt++;
            if (wr_cnt == WORDS) last_seen = 1;
         end
      end
   end

   task automatic push_image(input int s);
      exp_q.delete();
      for (int k = 0; k < WORDS; k++) exp_q.push_back({32'(k * 4), word_at(k, s)});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!rd_req && !wr_en && !core_run && !done, "R1", "async reset outputs",
            {rd_req, wr_en, core_run, done}, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_done();
      while (!done && cyc < LIMIT) @(negedge clk);
      check(cyc < LIMIT, "R4", "watchdog", cyc, LIMIT);
      @(negedge clk);
   endtask

   task automatic full_run(input int s, input int mode, input string tag);
      seed = s; lat_mode = mode;
      push_image(s);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_req === 1'b1, "R2", {tag, " first request"}, rd_req, 1);
      wait_done();
      check(wr_cnt == WORDS, "R3", {tag, " write count"}, wr_cnt, WORDS);
      check(exp_q.size() == 0, "R3", {tag, " all items seen"}, exp_q.size(), 0);
      check(core_run && done, "R4", {tag, " core released"}, {core_run, done}, 2'b11);
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(!rd_req && !wr_en && !core_run && !done, "R1", "reset state",
            {rd_req, wr_en, core_run, done}, 0);

      // run 1: zero wait memory
      full_run(0, 0, "zero-wait");

      // R6 R8 stray strobes after completion
      for (int i = 0; i < 3; i++) begin
         stray_want++;
         repeat (4) @(negedge clk);
      end
      repeat (10) @(negedge clk);
      check(wr_cnt == WORDS, "R6", "stray strobes caused no write", wr_cnt, WORDS);
      check(core_run && done && !rd_req, "R8", "release sticky", {core_run, done, rd_req}, 3'b110);

      // run 2: varying latency
      do_reset();
      full_run(5, 1, "varied-latency");

      // run 3: abort mid copy, then full restart (R9)
      do_reset();
      seed = 9; lat_mode = 2;
      push_image(9);
      rst_n = 1'b1;
      while (wr_cnt < 40 && cyc < LIMIT) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!rd_req && !wr_en && !core_run && !done, "R9", "abort clears outputs",
            {rd_req, wr_en, core_run, done}, 0);
      repeat (3) @(negedge clk);
      full_run(9, 2, "restart R9");

      // run 4: no-boot (R7)
      do_reset();
      boot_en = 1'b0;
      push_image(0);
      exp_q.delete();
      rst_n = 1'b1;
      @(negedge clk);
      check(core_run && done, "R7", "no-boot release on first edge", {core_run, done}, 2'b11);
      repeat (20) @(negedge clk);
      check(wr_cnt == 0 && req_cnt == 0, "R7", "no-boot traffic", {wr_cnt[15:0], req_cnt[15:0]}, 0);

      tests += m_tests + r_tests;
      fails += m_fails + r_fails;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule